// File: doc/BRIEF.md
# Serial Page-Flash Geometry Prober

This block runs once after every reset. It identifies a page-organised serial flash on an SPI bus and reports the flash geometry. The geometry is the number of pages, the bytes per page, the number of bits that the page byte offset takes up inside a flash address, and whether the page size is a power of two. The block drives the bus itself as an SPI mode 0 master, sending the most significant bit first. When it finishes, it raises either a result-valid pulse or an error pulse for one cycle. It then holds its outputs and leaves the bus idle until the next reset.

Identification has two stages.

- **Identity frame.** The block first reads the five-byte manufacturer and device identity. A recognised manufacturer leads to a lookup in a small table. The full five-byte extended identity is tried before the three-byte identity. Parts that can run with either page size need a second frame, a status read. Status bit 0 of that read chooses between the binary and the non-binary layout.
- **Legacy fallback.** If the manufacturer byte is not the expected one, the block reads the status byte instead. It decodes the density field in bits [5:2] of that byte, using an older scheme.

Top module: `sflash_probe`

## Requirements
- R1: After reset, with chip select held high for at least CS_GAP cycles, the block sends one frame of six bytes. The first byte is the opcode 0x9F and five response bytes follow. The frame uses SPI mode 0 (clock low while idle, data sampled on the rising edge, most significant bit first).
- R2: If the first identity byte equals 0x1F, the device bytes (identity bytes 1 and 2) are looked up. 0x22, 0x23, 0x24 and 0x25 give 512, 1024, 2048 and 4096 pages with pages of 264/256 bytes and an offset of 9/8. 0x26 gives 4096 pages of 528/512 bytes with an offset of 10/9. 0x2701 gives 8192 pages of 528/512 bytes. 0x28 gives 8192 pages of 1056/1024 bytes with an offset of 11/10. The first value of each pair is the non-binary layout and the second is the binary layout.
- R3: The five identity bytes 1F 28 00 01 00 match the extended entry: 32768 pages of 264/256 bytes with an offset of 9/8. This match takes priority over the three-byte 1F 28 00 entry.
- R4: For a dual-size part, a second frame is sent: opcode 0xD7 followed by one byte that is read. If status bit 0 is 1, the result is the binary layout with the power-of-two flag set. If the bit is 0, the result is the non-binary layout with the flag clear.
- R5: The identity 1F 27 00 selects a single-size part with 8192 pages of 528 bytes and an offset of 10. The result comes without any status frame.
- R6: If the first identity byte is not 0x1F, a status frame (0xD7) is sent and `status & 0x3C` is decoded, with the power-of-two flag always clear. 0x0C gives 512 pages of 264 bytes, offset 9. 0x14 gives 1024 pages and 0x1C gives 2048 pages, both of 264 bytes. 0x24 gives 4096 pages of 264 bytes. 0x2C gives 4096 pages of 528 bytes, offset 10. 0x34 gives 8192 pages of 528 bytes. Both 0x38 and 0x3C give 8192 pages of 1056 bytes, offset 11.
- R7: In the legacy path, a status byte of exactly 0x00 or 0xFF produces an error pulse with err_kind = 1 (no device).
- R8: Two cases produce an error pulse with err_kind = 2 (unsupported device): any other legacy density code, or a 0x1F identity that has no table entry.
- R9: Each run ends with exactly one pulse of one cycle, either geo_valid or geo_err, and never both at once. After that pulse no further frame is started and chip select stays high. The result outputs are stable from the pulse onward.
- R10: Chip select stays high for at least CS_GAP clock cycles between the identity frame and the status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; its release starts identification |
| spi_sck | output | 1 | SPI serial clock, low while idle |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| geo_valid | output | 1 | One-cycle pulse: geometry outputs are valid |
| geo_err | output | 1 | One-cycle pulse: identification failed |
| err_kind | output | 2 | 0 none, 1 no device, 2 unsupported device |
| page_count | output | 16 | Number of pages |
| page_bytes | output | 11 | Bytes per page |
| addr_shift | output | 4 | Bit position of the page number in a flash address |
| pow2_pages | output | 1 | Page size is a power of two |

## Verification
Different internal faults show up at different points, and each one is visible at the ports.

- **Byte counter.** A wrong count shows as a wrong frame length, or as identity bytes shifted by one byte. Either is visible on the bus as soon as chip select rises.
- **Path choice.** A wrong choice between the identity path and the legacy path shows as a missing or extra status frame before the result pulse. Choosing the wrong table entry, or the wrong status bit, shows as a geometry mismatch at that same pulse.
- **Stuck state.** A machine that does not settle after finishing shows a chip-select fall or a second pulse within the quiet window that follows each result.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
   localparam int PAGES_W = 16;
   localparam int BYTES_W = 11;
   localparam int SHIFT_W = 4;

   typedef struct packed {
      logic [PAGES_W-1:0] pages;
      logic [BYTES_W-1:0] np_bytes;
      logic [SHIFT_W-1:0] np_shift;
      logic [BYTES_W-1:0] p2_bytes;
      logic [SHIFT_W-1:0] p2_shift;
      logic               dual;
   } geo_ent_t;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_ABSENT = 2'd1,
      ERR_UNSUPP = 2'd2
   } err_kind_e;

   function automatic geo_ent_t mk_ent(input int pages, input int nb, input int ns,
                                       input int pb, input int ps, input bit dual);
      geo_ent_t g;
      g.pages    = PAGES_W'(pages);
      g.np_bytes = BYTES_W'(nb);
      g.np_shift = SHIFT_W'(ns);
      g.p2_bytes = BYTES_W'(pb);
      g.p2_shift = SHIFT_W'(ps);
      g.dual     = dual;
      return g;
   endfunction
endpackage

// File: rtl/sfp_byte_xfer.sv
module sfp_byte_xfer #(
   parameter int SCK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte
);
   localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

   logic [DIV_W-1:0] div_q;
   logic [2:0]       bit_q;
   logic [7:0]       tx_sh;
   logic [7:0]       rx_sh;

   assign mosi = tx_sh[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q   <= '0;
         bit_q   <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         sck     <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               busy  <= 1'b1;
               tx_sh <= tx_byte;
               div_q <= '0;
               bit_q <= '0;
               sck   <= 1'b0;
            end
         end else if (div_q != DIV_W'(SCK_HALF - 1)) begin
            div_q <= div_q + 1'b1;
         end else begin
            div_q <= '0;
            if (!sck) begin
               sck   <= 1'b1;
               rx_sh <= {rx_sh[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rx_byte <= rx_sh;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/sfp_id_match.sv
module sfp_id_match
   import sfp_pkg::*;
#(
   parameter logic [7:0] MFR_CODE  = 8'h1F,
   parameter bit         EXT_ID_EN = 1'b1
) (
   input  logic [39:0] id_bytes,
   output logic        mfr_ok,
   output logic        hit,
   output geo_ent_t    ent
);
   logic     std_hit;
   geo_ent_t std_ent;
   logic     ext_hit;
   geo_ent_t ext_ent;

   assign mfr_ok = (id_bytes[39:32] == MFR_CODE);

   always_comb begin
      std_hit = 1'b1;
      std_ent = mk_ent(0, 0, 0, 0, 0, 1'b0);
      case (id_bytes[31:16])
         16'h2200: std_ent = mk_ent(512,   264, 9,  256, 8,  1'b1);
         16'h2300: std_ent = mk_ent(1024,  264, 9,  256, 8,  1'b1);
         16'h2400: std_ent = mk_ent(2048,  264, 9,  256, 8,  1'b1);
         16'h2500: std_ent = mk_ent(4096,  264, 9,  256, 8,  1'b1);
         16'h2600: std_ent = mk_ent(4096,  528, 10, 512, 9,  1'b1);
         16'h2700: std_ent = mk_ent(8192,  528, 10, 528, 10, 1'b0);
         16'h2701: std_ent = mk_ent(8192,  528, 10, 512, 9,  1'b1);
         16'h2800: std_ent = mk_ent(8192, 1056, 11, 1024, 10, 1'b1);
         default:  std_hit = 1'b0;
      endcase
      if (!mfr_ok) std_hit = 1'b0;
   end

   generate
      if (EXT_ID_EN) begin : g_ext
         assign ext_hit = mfr_ok && (id_bytes[31:0] == 32'h2800_0100);
         assign ext_ent = mk_ent(32768, 264, 9, 256, 8, 1'b1);
      end else begin : g_noext
         assign ext_hit = 1'b0;
         assign ext_ent = '0;
      end
   endgenerate

   assign hit = ext_hit | std_hit;
   assign ent = ext_hit ? ext_ent : std_ent;
endmodule

// File: rtl/sfp_legacy_decode.sv
module sfp_legacy_decode
   import sfp_pkg::*;
(
   input  logic [7:0] status,
   output logic       absent,
   output logic       hit,
   output geo_ent_t   ent
);
   always_comb begin
      absent = (status == 8'h00) || (status == 8'hFF);
      hit    = 1'b1;
      ent    = mk_ent(0, 0, 0, 0, 0, 1'b0);
      case (status & 8'h3C)
         8'h0C:        ent = mk_ent(512,  264,  9,  264,  9,  1'b0);
         8'h14:        ent = mk_ent(1024, 264,  9,  264,  9,  1'b0);
         8'h1C:        ent = mk_ent(2048, 264,  9,  264,  9,  1'b0);
         8'h24:        ent = mk_ent(4096, 264,  9,  264,  9,  1'b0);
         8'h2C:        ent = mk_ent(4096, 528,  10, 528,  10, 1'b0);
         8'h34:        ent = mk_ent(8192, 528,  10, 528,  10, 1'b0);
         8'h38, 8'h3C: ent = mk_ent(8192, 1056, 11, 1056, 11, 1'b0);
         default:      hit = 1'b0;
      endcase
      if (absent) hit = 1'b0;
   end
endmodule

// File: rtl/sflash_probe.sv
module sflash_probe
   import sfp_pkg::*;
#(
   parameter int         SCK_HALF  = 2,
   parameter int         CS_GAP    = 4,
   parameter bit         EXT_ID_EN = 1'b1,
   parameter logic [7:0] MFR_CODE  = 8'h1F
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                spi_sck,
   output logic                spi_cs_n,
   output logic                spi_mosi,
   input  logic                spi_miso,
   output logic                geo_valid,
   output logic                geo_err,
   output logic [1:0]          err_kind,
   output logic [PAGES_W-1:0]  page_count,
   output logic [BYTES_W-1:0]  page_bytes,
   output logic [SHIFT_W-1:0]  addr_shift,
   output logic                pow2_pages
);
   localparam int         ID_BYTES = 5;
   localparam int         GAP_W    = $clog2(CS_GAP + 1);
   localparam logic [7:0] OP_ID    = 8'h9F;
   localparam logic [7:0] OP_STAT  = 8'hD7;

   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
   endgenerate

   typedef enum logic [2:0] {
      ST_GAP_ID, ST_ID, ST_ID_EVAL, ST_GAP_ST, ST_ST, ST_ST_EVAL, ST_DONE
   } state_e;

   state_e             state;
   logic [GAP_W-1:0]   gap_q;
   logic [2:0]         byte_q;
   logic               cs_n_q;
   logic               go_q;
   logic [7:0]         tx_q;
   logic [8*ID_BYTES-1:0] id_q;
   logic [7:0]         stat_q;
   logic               legacy_q;
   geo_ent_t           ent_q;

   logic               x_busy, x_done;
   logic [7:0]         x_rx;
   logic               id_mfr_ok, id_hit;
   geo_ent_t           id_ent;
   logic               leg_absent, leg_hit;
   geo_ent_t           leg_ent;

   sfp_byte_xfer #(.SCK_HALF(SCK_HALF)) u_xfer (
      .clk(clk), .rst_n(rst_n), .go(go_q), .tx_byte(tx_q), .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .busy(x_busy), .done(x_done), .rx_byte(x_rx)
   );

   sfp_id_match #(.MFR_CODE(MFR_CODE), .EXT_ID_EN(EXT_ID_EN)) u_idm (
      .id_bytes(id_q), .mfr_ok(id_mfr_ok), .hit(id_hit), .ent(id_ent)
   );

   sfp_legacy_decode u_leg (
      .status(stat_q), .absent(leg_absent), .hit(leg_hit), .ent(leg_ent)
   );

   assign spi_cs_n = cs_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_GAP_ID;
         gap_q      <= '0;
         byte_q     <= '0;
         cs_n_q     <= 1'b1;
         go_q       <= 1'b0;
         tx_q       <= '0;
         id_q       <= '0;
         stat_q     <= '0;
         legacy_q   <= 1'b0;
         ent_q      <= '0;
         geo_valid  <= 1'b0;
         geo_err    <= 1'b0;
         err_kind   <= ERR_NONE;
         page_count <= '0;
         page_bytes <= '0;
         addr_shift <= '0;
         pow2_pages <= 1'b0;
      end else begin
         go_q      <= 1'b0;
         geo_valid <= 1'b0;
         geo_err   <= 1'b0;
         case (state)
            ST_GAP_ID: begin
               if (gap_q == GAP_W'(CS_GAP - 1)) begin
                  cs_n_q <= 1'b0;
                  go_q   <= 1'b1;
                  tx_q   <= OP_ID;
                  byte_q <= '0;
                  state  <= ST_ID;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_ID: begin
               if (x_done && !x_busy) begin
                  if (byte_q != 3'd0) id_q <= {id_q[8*ID_BYTES-9:0], x_rx};
                  if (byte_q == 3'(ID_BYTES)) begin
                     cs_n_q <= 1'b1;
                     state  <= ST_ID_EVAL;
                  end else begin
                     go_q   <= 1'b1;
                     tx_q   <= 8'h00;
                     byte_q <= byte_q + 1'b1;
                  end
               end
            end
            ST_ID_EVAL: begin
               gap_q <= '0;
               if (!id_mfr_ok) begin
                  legacy_q <= 1'b1;
                  state    <= ST_GAP_ST;
               end else if (!id_hit) begin
                  geo_err  <= 1'b1;
                  err_kind <= ERR_UNSUPP;
                  state    <= ST_DONE;
               end else if (id_ent.dual) begin
                  legacy_q <= 1'b0;
                  ent_q    <= id_ent;
                  state    <= ST_GAP_ST;
               end else begin
                  geo_valid  <= 1'b1;
                  err_kind   <= ERR_NONE;
                  page_count <= id_ent.pages;
                  page_bytes <= id_ent.np_bytes;
                  addr_shift <= id_ent.np_shift;
                  pow2_pages <= 1'b0;
                  state      <= ST_DONE;
               end
            end
            ST_GAP_ST: begin
               if (gap_q == GAP_W'(CS_GAP - 1)) begin
                  cs_n_q <= 1'b0;
                  go_q   <= 1'b1;
                  tx_q   <= OP_STAT;
                  byte_q <= '0;
                  state  <= ST_ST;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_ST: begin
               if (x_done && !x_busy) begin
                  if (byte_q == 3'd0) begin
                     go_q   <= 1'b1;
                     tx_q   <= 8'h00;
                     byte_q <= 3'd1;
                  end else begin
                     stat_q <= x_rx;
                     cs_n_q <= 1'b1;
                     state  <= ST_ST_EVAL;
                  end
               end
            end
            ST_ST_EVAL: begin
               state <= ST_DONE;
               if (legacy_q) begin
                  if (leg_absent) begin
                     geo_err  <= 1'b1;
                     err_kind <= ERR_ABSENT;
                  end else if (!leg_hit) begin
                     geo_err  <= 1'b1;
                     err_kind <= ERR_UNSUPP;
                  end else begin
                     geo_valid  <= 1'b1;
                     err_kind   <= ERR_NONE;
                     page_count <= leg_ent.pages;
                     page_bytes <= leg_ent.np_bytes;
                     addr_shift <= leg_ent.np_shift;
                     pow2_pages <= 1'b0;
                  end
               end else begin
                  geo_valid  <= 1'b1;
                  err_kind   <= ERR_NONE;
                  page_count <= ent_q.pages;
                  if (stat_q[0]) begin
                     page_bytes <= ent_q.p2_bytes;
                     addr_shift <= ent_q.p2_shift;
                     pow2_pages <= 1'b1;
                  end else begin
                     page_bytes <= ent_q.np_bytes;
                     addr_shift <= ent_q.np_shift;
                     pow2_pages <= 1'b0;
                  end
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
   parameter int CS_GAP = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        sck,
   input logic        geo_valid,
   input logic        geo_err,
   input logic [10:0] page_bytes,
   input logic [3:0]  addr_shift,
   input logic        pow2
);
   localparam int HW = $clog2(CS_GAP + 1) + 1;

   logic [HW-1:0] hi_cnt;
   logic          done_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt    <= '0;
         done_seen <= 1'b0;
      end else begin
         if (!cs_n)                     hi_cnt <= '0;
         else if (hi_cnt < HW'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
         if (geo_valid || geo_err) done_seen <= 1'b1;
      end
   end

   AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(geo_valid && geo_err)); // R9
   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid || geo_err) |=> !(geo_valid || geo_err)); // R9
   AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      done_seen |-> cs_n); // R9
   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck); // R1
   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> hi_cnt >= HW'(CS_GAP)); // R10
   AST_POW2_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid && pow2) |-> (32'(page_bytes) == (32'd1 << addr_shift))); // R4
   AST_NONPOW2_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid && !pow2) |-> ((32'(page_bytes) > (32'd1 << (addr_shift - 4'd1)))
                                && (32'(page_bytes) < (32'd1 << addr_shift)))); // R2
endmodule

bind sflash_probe sfp_checker #(.CS_GAP(CS_GAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
   .geo_valid(geo_valid), .geo_err(geo_err), .page_bytes(page_bytes),
   .addr_shift(addr_shift), .pow2(pow2_pages)
);

// File: tb/sflash_probe_tb_top.sv
`timescale 1ns/1ps
module sflash_probe_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
   logic geo_valid, geo_err;
   logic [1:0]  err_kind;
   logic [15:0] page_count;
   logic [10:0] page_bytes;
   logic [3:0]  addr_shift;
   logic        pow2_pages;

   always #2.5 clk = ~clk;

   sflash_probe dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .geo_valid(geo_valid),
      .geo_err(geo_err), .err_kind(err_kind), .page_count(page_count),
      .page_bytes(page_bytes), .addr_shift(addr_shift), .pow2_pages(pow2_pages)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   logic [7:0] id_b [5];
   logic [7:0] st_b;
   int         bitcnt = 0;
   int         frames = 0;
   logic [7:0] op_sh = 8'h00;
   logic [7:0] op_f  [64];
   int         len_f [64];

   always @(negedge spi_cs_n) frames++;

   always @(posedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         if (frames > 0) len_f[frames & 63] = bitcnt;
         bitcnt = 0;
      end else begin
         if (bitcnt < 8) op_sh = {op_sh[6:0], spi_mosi};
         if (bitcnt == 7) op_f[frames & 63] = op_sh;
         bitcnt++;
      end
   end

   always @* begin
      logic [7:0] rb;
      int bi;
      bi = bitcnt / 8 - 1;
      if (op_sh == 8'h9F) rb = (bi >= 0 && bi < 5) ? id_b[bi] : 8'h00;
      else                rb = st_b;
      if (spi_cs_n || bitcnt < 8) spi_miso = 1'b0;
      else                        spi_miso = rb[7 - (bitcnt % 8)];
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_err;
      logic [1:0]  ek;
      int          pages;
      int          bytes;
      int          shift;
      bit          p2;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_done = 0;

   always @(negedge clk) begin
      if (rst_n && (geo_valid || geo_err)) begin
         n_done++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected extra result", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(geo_err == e.is_err, {e.tag, " error flag"}, int'(geo_err), int'(e.is_err));
            chk(!(geo_valid && geo_err), "R9 both pulses", 1, 0);
            if (e.is_err) begin
               chk(err_kind == e.ek, {e.tag, " err_kind"}, int'(err_kind), int'(e.ek));
            end else begin
               chk(int'(page_count) == e.pages, {e.tag, " page_count"}, int'(page_count), e.pages);
               chk(int'(page_bytes) == e.bytes, {e.tag, " page_bytes"}, int'(page_bytes), e.bytes);
               chk(int'(addr_shift) == e.shift, {e.tag, " addr_shift"}, int'(addr_shift), e.shift);
               chk(pow2_pages == e.p2, {e.tag, " pow2_pages"}, int'(pow2_pages), int'(e.p2));
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic run_case(input logic [39:0] id, input logic [7:0] st,
                           input bit is_err, input logic [1:0] ek,
                           input int pages, input int bytes, input int shift,
                           input bit p2, input int exp_frames, input string tag);
      exp_t e;
      int fb, nd, waited;
      e.is_err = is_err; e.ek = ek; e.pages = pages; e.bytes = bytes;
      e.shift = shift; e.p2 = p2; e.tag = tag;
      for (int i = 0; i < 5; i++) id_b[i] = id[39 - 8*i -: 8];
      st_b = st;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state: bus idle, no result pulse
      chk(spi_cs_n == 1'b1, "R1 reset cs_n", int'(spi_cs_n), 1);
      chk(spi_sck == 1'b0, "R1 reset sck", int'(spi_sck), 0);
      chk(!geo_valid && !geo_err, "R9 reset pulses", int'(geo_valid | geo_err), 0);
      exp_q.push_back(e);
      fb = frames;
      nd = n_done;
      rst_n = 1'b1;
      waited = 0;
      while (n_done == nd && waited < 4000) begin
         @(negedge clk);
         waited++;
      end
      chk(n_done != nd, {tag, " result produced"}, n_done - nd, 1);
      // R1: identity frame opcode and length
      chk(op_f[(fb + 1) & 63] == 8'h9F, "R1 identity opcode", int'(op_f[(fb + 1) & 63]), 'h9F);
      chk(len_f[(fb + 1) & 63] == 48, "R1 identity frame bits", len_f[(fb + 1) & 63], 48);
      chk(frames - fb == exp_frames, {tag, " frame count (R5/R6)"}, frames - fb, exp_frames);
      if (exp_frames == 2) begin
         // R4/R6 status frame
         chk(op_f[(fb + 2) & 63] == 8'hD7, "R4 status opcode", int'(op_f[(fb + 2) & 63]), 'hD7);
         chk(len_f[(fb + 2) & 63] == 16, "R4 status frame bits", len_f[(fb + 2) & 63], 16);
      end
      // R9: quiet afterwards
      repeat (150) @(negedge clk);
      chk(frames - fb == exp_frames, "R9 no frame after result", frames - fb, exp_frames);
      chk(spi_cs_n == 1'b1, "R9 cs_n high after result", int'(spi_cs_n), 1);
   endtask

   initial begin
      st_b = 8'h00;
      for (int i = 0; i < 5; i++) id_b[i] = 8'h00;
      repeat (4) @(negedge clk);
      run_case(40'h1F24000000, 8'h01, 0, 2'd0, 2048, 256, 8, 1, 2, "R4 dual binary");
      run_case(40'h1F24000000, 8'hAC, 0, 2'd0, 2048, 264, 9, 0, 2, "R4 dual non-binary");
      run_case(40'h1F26000000, 8'hAD, 0, 2'd0, 4096, 512, 9, 1, 2, "R2 table 0x26");
      run_case(40'h1F22000000, 8'h00, 0, 2'd0, 512, 264, 9, 0, 2, "R2 table 0x22");
      run_case(40'h1F27000000, 8'h01, 0, 2'd0, 8192, 528, 10, 0, 1, "R5 single size");
      run_case(40'h1F28000100, 8'h01, 0, 2'd0, 32768, 256, 8, 1, 2, "R3 extended id");
      run_case(40'h1F28000000, 8'hBC, 0, 2'd0, 8192, 1056, 11, 0, 2, "R3 three-byte id");
      run_case(40'h1F99000000, 8'h01, 1, 2'd2, 0, 0, 0, 0, 1, "R8 unknown id");
      run_case(40'h0000000000, 8'hAC, 0, 2'd0, 4096, 528, 10, 0, 2, "R6 legacy 0x2C");
      run_case(40'h7F00000000, 8'h9C, 0, 2'd0, 2048, 264, 9, 0, 2, "R6 legacy 0x1C");
      run_case(40'h0000000000, 8'hB8, 0, 2'd0, 8192, 1056, 11, 0, 2, "R6 legacy 0x38");
      run_case(40'h0000000000, 8'h8D, 0, 2'd0, 512, 264, 9, 0, 2, "R6 legacy 0x0C bit0");
      run_case(40'h0000000000, 8'hB4, 0, 2'd0, 8192, 528, 10, 0, 2, "R6 legacy 0x34");
      run_case(40'h0000000000, 8'h00, 1, 2'd1, 0, 0, 0, 0, 2, "R7 absent 00");
      run_case(40'h0000000000, 8'hFF, 1, 2'd1, 0, 0, 0, 0, 2, "R7 absent FF");
      run_case(40'h0000000000, 8'h90, 1, 2'd2, 0, 0, 0, 0, 2, "R8 legacy code 0x10");
      // R10 gap is watched by AST_CS_GAP on every two-frame case above
      chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule